// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps an effective address onto a real address through a handful of large, naturally aligned memory blocks. Each block is described by a pair of 32-bit configuration words. The upper word gives the block's effective base, its size and one enable bit for each privilege level. The lower word gives the real base and a two-bit protection code. A request presents an address, an access kind and the current privilege level. One cycle later the unit reports one of three results. A hit returns a translated address. A fault means a block matched but the access is not permitted. A miss means no enabled block covers the address, so a later page-level translation stage can take over.

A chip normally carries two copies of the unit: one on the instruction-fetch path and one on the load/store path. Each copy has its own register bank. The blocks that take part in a lookup are chosen from the privilege input of that same request. A change of privilege therefore applies to the very next request, with no reprogramming.

Top module: `bat_xlate`

## Requirements
- R1: After reset every pair is cleared, so both enable bits are 0. All response outputs read 0, and any request in either privilege level returns a miss.
- R2: A write with `cfg_wr_en`=1 stores `cfg_wr_data` into pair `cfg_wr_pair`. It goes to the upper word when `cfg_wr_hi`=1 and to the lower word otherwise. The change takes effect for requests issued after the write cycle.
- R3: Upper-word layout, LSB numbering: [31:17] block effective base, [12:2] length field L, [1] supervisor enable, [0] user enable. A pair is considered only when the enable bit for the current level is 1, with `priv_user`=0 meaning supervisor and 1 meaning user.
- R4: The length mask is M = (L << 17) | 0x1FFFF. An enabled pair matches when (addr & ~M) equals the upper word with its low 17 bits cleared. The smallest block is therefore 128 KB.
- R5: When several enabled pairs match, the lowest-numbered pair decides the result.
- R6: On a hit, `real_addr` = (addr & M) | (lower word with its low 17 bits cleared).
- R7: The protection code sits in lower-word bits [1:0]. Access encodings on `req_acc` are 0 = data read, 1 = data write, 2 = instruction fetch and 3 = treated as a read. Code 0 permits nothing. Codes 1 and 3 permit everything except data write. Code 2 permits everything.
- R8: When no enabled pair matches, the response has `miss`=1, `hit`=0, `fault`=0 and `real_addr`=0.
- R9: When the deciding pair forbids the access, the response has `fault`=1, `hit`=0, `miss`=0 and `real_addr`=0.
- R10: Every response appears exactly one cycle after a cycle with `req_valid`=1. In that response `rsp_valid`=1 and exactly one of hit, miss and fault is 1. In any other cycle all four flags are 0.
- R11: Changing `priv_user` between requests changes which pairs are enabled on the next request, with no register writes in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_pair | input | SEL_W (2) | Pair index written |
| cfg_wr_hi | input | 1 | 1 selects the upper word, 0 the lower word |
| cfg_wr_data | input | ADDR_W (32) | Word written |
| req_valid | input | 1 | Lookup request |
| priv_user | input | 1 | 1 = user level, 0 = supervisor level |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_addr | input | ADDR_W (32) | Effective address |
| rsp_valid | output | 1 | Response present |
| hit | output | 1 | Translated, access permitted |
| miss | output | 1 | No enabled block covers the address |
| fault | output | 1 | Block matched, access forbidden |
| real_addr | output | ADDR_W (32) | Translated address, 0 unless hit |

## Verification
A corrupted base, length or real-base field shows up in the response that follows the very next request touching that block. It appears as a wrong address, as a miss where a hit was due, or as a hit where a miss was due. A wrong enable bit or a wrong priority order gets past any one privilege level. It is caught by sweeping each address in both levels over overlapping blocks. A protection-table error shows only for particular access kinds, so every address is tried with all four encodings. Addresses sit at the first and last byte of each block and just outside it, so an off-by-one in the length mask changes a result within one request.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int BAT_AW = 32;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PROT_NONE = 2'd0,
        PROT_RO_A = 2'd1,
        PROT_RW   = 2'd2,
        PROT_RO_B = 2'd3
    } prot_code_e;

endpackage

// File: rtl/bat_regs.sv
module bat_regs #(
    parameter int NUM_PAIRS = 4,
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = $clog2(NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_pair,
    input  logic              wr_hi,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] upper_o [NUM_PAIRS],
    output logic [ADDR_W-1:0] lower_o [NUM_PAIRS]
);

    logic [ADDR_W-1:0] upper_d [NUM_PAIRS];
    logic [ADDR_W-1:0] upper_q [NUM_PAIRS];
    logic [ADDR_W-1:0] lower_d [NUM_PAIRS];
    logic [ADDR_W-1:0] lower_q [NUM_PAIRS];

    always_comb begin
        for (int i = 0; i < NUM_PAIRS; i++) begin
            upper_d[i] = upper_q[i];
            lower_d[i] = lower_q[i];
            if (wr_en && (int'(wr_pair) == i)) begin
                if (wr_hi) begin
                    upper_d[i] = wr_data;
                end else begin
                    lower_d[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PAIRS; i++) begin
                upper_q[i] <= '0;
                lower_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_PAIRS; i++) begin
                upper_q[i] <= upper_d[i];
                lower_q[i] <= lower_d[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_PAIRS; i++) begin
            upper_o[i] = upper_q[i];
            lower_o[i] = lower_q[i];
        end
    end

endmodule

// File: rtl/bat_pair_match.sv
module bat_pair_match #(
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 17,
    parameter int LEN_W     = 11
) (
    input  logic [ADDR_W-1:0] upper_i,
    input  logic [ADDR_W-1:0] lower_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              user_i,
    output logic              match_o,
    output logic [ADDR_W-1:0] ra_o,
    output logic [1:0]        pp_o
);

    localparam int LEN_LSB  = 2;
    localparam int SUP_BIT  = 1;
    localparam int USR_BIT  = 0;
    localparam int BASE_W   = ADDR_W - MIN_SHIFT;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << MIN_SHIFT) - 64'd1);

    logic [ADDR_W-1:0] len_mask;
    logic [ADDR_W-1:0] eff_base;
    logic [ADDR_W-1:0] real_base;
    logic              enabled;

    always_comb begin
        len_mask  = (ADDR_W'(upper_i[LEN_LSB +: LEN_W]) << MIN_SHIFT) | LOW_MASK;
        eff_base  = {upper_i[ADDR_W-1 -: BASE_W], {MIN_SHIFT{1'b0}}};
        real_base = {lower_i[ADDR_W-1 -: BASE_W], {MIN_SHIFT{1'b0}}};
        enabled   = user_i ? upper_i[USR_BIT] : upper_i[SUP_BIT];
        match_o   = enabled && ((addr_i & ~len_mask) == eff_base);
        ra_o      = (addr_i & len_mask) | real_base;
        pp_o      = lower_i[1:0];
    end

endmodule

// File: rtl/bat_perm.sv
module bat_perm
    import bat_pkg::*;
(
    input  logic [1:0] pp_i,
    input  logic [1:0] acc_i,
    output logic       allow_o
);

    prot_code_e code;
    acc_kind_e  kind;

    always_comb begin
        code = prot_code_e'(pp_i);
        kind = acc_kind_e'(acc_i);
        unique case (code)
            PROT_NONE: allow_o = 1'b0;
            PROT_RW:   allow_o = 1'b1;
            PROT_RO_A,
            PROT_RO_B: allow_o = (kind != ACC_STORE);
            default:   allow_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate #(
    parameter int NUM_PAIRS = 4,
    parameter int ADDR_W    = bat_pkg::BAT_AW,
    parameter int MIN_SHIFT = 17,
    parameter int LEN_W     = 11,
    parameter int SEL_W     = $clog2(NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_pair,
    input  logic              cfg_wr_hi,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic              req_valid,
    input  logic              priv_user,
    input  logic [1:0]        req_acc,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              hit,
    output logic              miss,
    output logic              fault,
    output logic [ADDR_W-1:0] real_addr
);

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic              miss;
        logic              fault;
        logic [ADDR_W-1:0] ra;
    } rsp_t;

    logic [ADDR_W-1:0] upper [NUM_PAIRS];
    logic [ADDR_W-1:0] lower [NUM_PAIRS];
    logic              pair_match [NUM_PAIRS];
    logic [ADDR_W-1:0] pair_ra    [NUM_PAIRS];
    logic [1:0]        pair_pp    [NUM_PAIRS];

    logic              any_match;
    logic [ADDR_W-1:0] sel_ra;
    logic [1:0]        sel_pp;
    logic              allowed;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    bat_regs #(
        .NUM_PAIRS (NUM_PAIRS),
        .ADDR_W    (ADDR_W),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_pair (cfg_wr_pair),
        .wr_hi   (cfg_wr_hi),
        .wr_data (cfg_wr_data),
        .upper_o (upper),
        .lower_o (lower)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        bat_pair_match #(
            .ADDR_W    (ADDR_W),
            .MIN_SHIFT (MIN_SHIFT),
            .LEN_W     (LEN_W)
        ) u_match (
            .upper_i (upper[g]),
            .lower_i (lower[g]),
            .addr_i  (req_addr),
            .user_i  (priv_user),
            .match_o (pair_match[g]),
            .ra_o    (pair_ra[g]),
            .pp_o    (pair_pp[g])
        );
    end

    // lowest index wins: scan downward so the last assignment is the lowest match
    always_comb begin
        any_match = 1'b0;
        sel_ra    = '0;
        sel_pp    = '0;
        for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
            if (pair_match[i]) begin
                any_match = 1'b1;
                sel_ra    = pair_ra[i];
                sel_pp    = pair_pp[i];
            end
        end
    end

    bat_perm u_perm (
        .pp_i    (sel_pp),
        .acc_i   (req_acc),
        .allow_o (allowed)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.vld = 1'b1;
            if (!any_match) begin
                rsp_d.miss = 1'b1;
            end else if (allowed) begin
                rsp_d.hit = 1'b1;
                rsp_d.ra  = sel_ra;
            end else begin
                rsp_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign hit       = rsp_q.hit;
    assign miss      = rsp_q.miss;
    assign fault     = rsp_q.fault;
    assign real_addr = rsp_q.ra;

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              hit,
    input logic              miss,
    input logic              fault,
    input logic [ADDR_W-1:0] real_addr
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({hit, miss, fault})); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(hit || miss || fault)); // R10

    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (real_addr == '0) && !fault); // R8

    AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (real_addr == '0)); // R9

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!hit || (real_addr[MIN_SHIFT-1:0] == $past(req_addr[MIN_SHIFT-1:0])))); // R6

endmodule

bind bat_xlate bat_xlate_chk #(
    .ADDR_W    (ADDR_W),
    .MIN_SHIFT (MIN_SHIFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .hit       (hit),
    .miss      (miss),
    .fault     (fault),
    .real_addr (real_addr)
);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_pair = '0;
    logic        cfg_wr_hi = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        priv_user = 1'b0;
    logic [1:0]  req_acc = '0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, hit, miss, fault;
    logic [31:0] real_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] bub [4];
    logic [31:0] blb [4];
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    bat_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_pair(cfg_wr_pair), .cfg_wr_hi(cfg_wr_hi),
        .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .priv_user(priv_user), .req_acc(req_acc),
        .req_addr(req_addr),
        .rsp_valid(rsp_valid), .hit(hit), .miss(miss), .fault(fault),
        .real_addr(real_addr)
    );

    function automatic logic [31:0] next_rand(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // expected {vld, hit, miss, fault, addr} from the requirements
    function automatic logic [35:0] model(logic [31:0] ea, logic user, logic [1:0] acc);
        logic        found;
        logic [1:0]  pp;
        logic [31:0] ra;
        logic [31:0] m;
        logic        en;
        logic        ok;
        found = 1'b0;
        pp = '0;
        ra = '0;
        for (int i = 0; i < 4; i++) begin
            en = user ? bub[i][0] : bub[i][1];
            m  = ({21'b0, bub[i][12:2]} << 17) | 32'h0001_FFFF;
            if (!found && en && ((ea & ~m) == (bub[i] & 32'hFFFE_0000))) begin
                found = 1'b1;
                pp = blb[i][1:0];
                ra = (ea & m) | (blb[i] & 32'hFFFE_0000);
            end
        end
        if (!found) return {4'b1010, 32'h0};
        ok = (pp == 2'd2) || ((pp != 2'd0) && (acc != 2'd1));
        return ok ? {4'b1100, ra} : {4'b1001, 32'h0};
    endfunction

    function automatic logic [35:0] observed();
        return {rsp_valid, hit, miss, fault, real_addr};
    endfunction

    task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int pair, bit hi, logic [31:0] data);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_pair = 2'(pair);
        cfg_wr_hi   = hi;
        cfg_wr_data = data;
        if (hi) bub[pair] = data; else blb[pair] = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic lookup(logic [31:0] ea, logic user, logic [1:0] acc, output logic [35:0] res);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ea;
        priv_user = user;
        req_acc   = acc;
        @(negedge clk);
        res = observed();
        req_valid = 1'b0;
    endtask

    task automatic sweep_one(logic [31:0] ea);
        logic [35:0] got;
        logic [35:0] exp;
        for (int u = 0; u < 2; u++) begin
            for (int a = 0; a < 4; a++) begin
                lookup(ea, u[0], 2'(a), got);
                exp = model(ea, u[0], 2'(a));
                if (exp[34])      chk("R6 hit address", got, exp);
                else if (exp[33]) chk("R8 miss", got, exp);
                else              chk("R9 fault", got, exp);
            end
        end
    endtask

    task automatic sweep_blocks();
        logic [31:0] m;
        logic [31:0] b;
        for (int i = 0; i < 4; i++) begin
            m = ({21'b0, bub[i][12:2]} << 17) | 32'h0001_FFFF;
            b = bub[i] & 32'hFFFE_0000;
            sweep_one(b);
            sweep_one(b + m);
            sweep_one(b + m + 32'd1);
            sweep_one(b - 32'd1);
            lfsr = next_rand(lfsr);
            sweep_one(b | (lfsr & m));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [35:0] got;
        for (int i = 0; i < 4; i++) begin
            bub[i] = '0;
            blb[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and empty bank
        chk("R1 outputs after reset", observed(), 36'h0);
        lookup(32'h0000_0000, 1'b0, 2'd0, got);
        chk("R1 supervisor miss after reset", got, {4'b1010, 32'h0});
        lookup(32'hFFFF_FFFC, 1'b1, 2'd2, got);
        chk("R1 user miss after reset", got, {4'b1010, 32'h0});

        // R10: no request, no response
        @(negedge clk);
        chk("R10 idle cycle quiet", observed(), 36'h0);

        // configuration A
        wr(0, 1'b1, 32'h0000_0002);             // base 0, 128 KB, supervisor
        wr(0, 1'b0, 32'h1000_0002);             // real 0x1000_0000, RW
        wr(1, 1'b1, 32'h0000_000F);             // base 0, 512 KB, both levels
        wr(1, 1'b0, 32'h2000_0001);             // read-only
        wr(2, 1'b1, 32'h4000_1FFD);             // 256 MB, user only
        wr(2, 1'b0, 32'h8000_0003);             // read-only
        wr(3, 1'b1, 32'h6000_0007);             // 256 KB, both levels
        wr(3, 1'b0, 32'hA000_0000);             // no access

        // R2: upper and lower words land where written
        lookup(32'h0000_1234, 1'b0, 2'd1, got);
        chk("R2 lower word real base", got, {4'b1100, 32'h1000_1234});

        // R5: overlapping pairs 0 and 1, supervisor -> pair 0 decides
        lookup(32'h0001_0000, 1'b0, 2'd1, got);
        chk("R5 lowest pair wins", got, {4'b1100, 32'h1001_0000});

        // R3 / R11: same address in user level skips pair 0
        lookup(32'h0001_0000, 1'b1, 2'd0, got);
        chk("R11 user level enables pair 1", got, {4'b1100, 32'h2001_0000});
        lookup(32'h0001_0000, 1'b1, 2'd1, got);
        chk("R3 user write hits read-only pair", got, {4'b1001, 32'h0});
        lookup(32'h4123_4567, 1'b0, 2'd0, got);
        chk("R3 supervisor ignores user-only pair", got, {4'b1010, 32'h0});
        lookup(32'h4123_4567, 1'b1, 2'd0, got);
        chk("R11 back to user level", got, {4'b1100, 32'h8123_4567});

        // R4: block edges
        lookup(32'h0007_FFFF, 1'b1, 2'd0, got);
        chk("R4 last byte of 512 KB block", got, {4'b1100, 32'h2007_FFFF});
        lookup(32'h0008_0000, 1'b1, 2'd0, got);
        chk("R4 first byte past block", got, {4'b1010, 32'h0});

        // R9: no-access code faults all kinds
        lookup(32'h6003_0000, 1'b0, 2'd2, got);
        chk("R9 code 0 fetch faults", got, {4'b1001, 32'h0});

        sweep_blocks();

        // R7: full protection sweep on pair 0
        for (int p = 0; p < 4; p++) begin
            wr(0, 1'b0, 32'h1000_0000 | 32'(p));
            for (int a = 0; a < 4; a++) begin
                lookup(32'h0000_0ABC, 1'b0, 2'(a), got);
                chk("R7 protection matrix", got, model(32'h0000_0ABC, 1'b0, 2'(a)));
            end
        end

        // misaligned base never matches its own low bits (R4)
        wr(3, 1'b1, 32'h6002_0007);
        lookup(32'h6002_0000, 1'b0, 2'd0, got);
        chk("R4 base bit inside mask blocks match", got, {4'b1010, 32'h0});

        // pseudo-random configurations
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 4; i++) begin
                lfsr = next_rand(lfsr);
                wr(i, 1'b1, lfsr & 32'hFFFE_1FFF & ~(32'(r) << 20));
                lfsr = next_rand(lfsr);
                wr(i, 1'b0, lfsr);
            end
            sweep_blocks();
        end

        @(negedge clk);
        chk("R10 quiet after last request", observed(), 36'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule